// File: doc/BRIEF.md
# NAND Command/Address/Data Host Port

This block sits between a simple host request interface and a parallel NAND flash device that is wired to one of several chip selects. Each chip select offers three host windows, and the window a write lands in decides the device cycle: a command window write becomes a command latch cycle, an address window write becomes an address latch cycle, and a data window write is a plain data transfer. Every host read, whichever window it names, is a device data read. A fourth window code carries no device cycle; a write there loads the write-protect bit, which every chip select shares.

The port generates the write strobe, read strobe and per-select chip enable itself, with low and high phase lengths taken from two hold-count inputs. A two-bit configuration field selects an 8-bit or a 16-bit device bus, and command bytes are always sent as 8-bit transfers. A busy flag tells the host when it may issue the next request. Read data is latched as the read strobe rises and is handed back with a single-cycle valid pulse.

Top module: `nand_cmd_port`

## Requirements
- R1: A write with window code 2'b01 (command) drives CLE high and ALE low for the whole cycle. It drives only wdata[7:0] on dq_out[7:0] with dq_out[15:8] = 0, on both 8-bit and 16-bit devices.
- R2: A write with window code 2'b10 (address) drives ALE high and CLE low for the whole cycle.
- R3: A write with window code 2'b00 (data) keeps CLE and ALE low. It drives dq_out with output enable high while the cycle lasts.
- R4: A read with any window code keeps CLE, ALE and WE# high/low at 0/0/1, lowers RE#, and leaves the output enable low. The dq_in value present when RE# rises is returned on host_rdata, together with a host_rvalid pulse lasting exactly one clock.
- R5: The device bus is 16 bits wide only when cfg_width = 2'b01, and 8 bits for any other value. On an 8-bit device, data and address writes drive dq_out[15:8] = 0 and reads return host_rdata[15:8] = 0.
- R6: During a cycle, exactly the addressed chip select has its CE# low. While the port is idle, all CE# lines are high.
- R7: The active strobe is low for L clocks and then high for H clocks, with CE# still low. L and H are the low_cnt and high_cnt values present at the request, from 1 to 15, and a count of 0 acts as 1. host_busy is high for exactly L+H clocks, starting the clock after the request is accepted.
- R8: A request whose chip-select index is NUM_CS (4) or higher is dropped. No strobe, CE# or busy follows.
- R9: wp_n is 0 (protected) after reset. A write with window code 2'b11 sets wp_n to wdata[0] from the next clock, for all chip selects, and starts no device cycle.
- R10: Requests presented while host_busy is high are ignored. They neither start a cycle nor change CE#.
- R11: After reset, both strobes are high, all CE# lines are high, CLE, ALE, output enable, busy and rvalid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Request strobe, accepted when host_busy is low |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_cs | input | 3 | Chip-select index |
| host_win | input | 2 | Window: 00 data, 01 command, 10 address, 11 write-protect control |
| host_wdata | input | 16 | Write data |
| host_busy | output | 1 | Device cycle in progress |
| host_rdata | output | 16 | Captured read data |
| host_rvalid | output | 1 | One-clock read data valid pulse |
| cfg_width | input | 2 | Bus width field, 2'b01 = 16 bits |
| low_cnt | input | 4 | Strobe low phase length in clocks |
| high_cnt | input | 4 | Strobe high phase length in clocks |
| nand_ce_n | output | 4 | Per-select chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_wp_n | output | 1 | Write protect, active low |
| nand_dq_out | output | 16 | Device data out |
| nand_dq_oe | output | 1 | Device data output enable |
| nand_dq_in | input | 16 | Device data in |

## Verification
The clock edge that accepts a request starts the cycle. From the following clock, the strobe is low for L clocks and high for H clocks, and busy drops at the edge L+H after acceptance. The read result and its valid pulse appear on the same edge where RE# rises, so they are visible in the first sample of the high phase. The write-protect output changes one edge after its control write. The bench changes its inputs and samples on the falling clock edge, and walks each scenario one sample per clock across these phase boundaries, so every level is compared in exactly the clock it is due.

// File: rtl/nand_port_pkg.sv
package nand_port_pkg;

   typedef enum logic [1:0] {
      WIN_DATA = 2'b00,
      WIN_CMD  = 2'b01,
      WIN_ADDR = 2'b10,
      WIN_CTRL = 2'b11
   } win_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'b00,
      PH_LOW  = 2'b01,
      PH_HIGH = 2'b10
   } phase_e;

   typedef struct packed {
      logic rd;
      logic cle;
      logic ale;
      logic byte_only;
   } cyc_kind_t;

   localparam logic [1:0] WIDE_CODE = 2'b01;

endpackage

// File: rtl/nand_req_decode.sv
module nand_req_decode
   import nand_port_pkg::*;
#(
   parameter int NUM_CS   = 4,
   parameter int CS_IDX_W = 3
) (
   input  logic                 req,
   input  logic                 wr,
   input  logic [CS_IDX_W-1:0]  cs,
   input  logic [1:0]           win,
   input  logic                 busy,
   output logic                 start,
   output logic                 wp_load,
   output cyc_kind_t            kind,
   output logic [NUM_CS-1:0]    ce_sel
);

   localparam logic [CS_IDX_W:0] CS_LIMIT = (CS_IDX_W+1)'(NUM_CS);

   logic idle_req;
   logic cs_ok;
   logic is_ctrl;

   assign idle_req = req && !busy;
   assign cs_ok    = ({1'b0, cs} < CS_LIMIT);
   assign is_ctrl  = wr && (win_e'(win) == WIN_CTRL);

   assign wp_load = idle_req && is_ctrl;
   assign start   = idle_req && cs_ok && !is_ctrl;

   always_comb begin
      kind.rd        = !wr;
      kind.cle       = wr && (win_e'(win) == WIN_CMD);
      kind.ale       = wr && (win_e'(win) == WIN_ADDR);
      kind.byte_only = wr && (win_e'(win) == WIN_CMD);
   end

   for (genvar g = 0; g < NUM_CS; g++) begin : g_sel
      assign ce_sel[g] = (cs == CS_IDX_W'(g));
   end

endmodule

// File: rtl/nand_phase_timer.sv
module nand_phase_timer
   import nand_port_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  low_cnt,
   input  logic [CNT_W-1:0]  high_cnt,
   output phase_e            phase,
   output logic              busy,
   output logic              rise
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] high_q;

   function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
      return (v == '0) ? CNT_W'(1) : v;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         cnt_q  <= '0;
         high_q <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase  <= PH_LOW;
                  cnt_q  <= at_least_one(low_cnt) - CNT_W'(1);
                  high_q <= at_least_one(high_cnt) - CNT_W'(1);
               end
            end
            PH_LOW: begin
               if (cnt_q == '0) begin
                  phase <= PH_HIGH;
                  cnt_q <= high_q;
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            PH_HIGH: begin
               if (cnt_q == '0) begin
                  phase <= PH_IDLE;
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign busy = (phase != PH_IDLE);
   assign rise = (phase == PH_LOW) && (cnt_q == '0);

endmodule

// File: rtl/nand_data_path.sv
module nand_data_path #(
   parameter int DQ_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             byte_only,
   input  logic             wide,
   input  logic [DQ_W-1:0]  wdata,
   input  logic             capture,
   input  logic [DQ_W-1:0]  dq_in,
   output logic [DQ_W-1:0]  dq_out,
   output logic [DQ_W-1:0]  rdata,
   output logic             rvalid
);

   logic [DQ_W-1:0] wr_shaped;
   logic [DQ_W-1:0] rd_shaped;

   if (DQ_W == 16) begin : g_dual_width
      logic wide_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) wide_q <= 1'b0;
         else if (start) wide_q <= wide;
      end

      assign wr_shaped = (byte_only || !wide) ? {8'h00, wdata[7:0]} : wdata;
      assign rd_shaped = wide_q ? dq_in : {8'h00, dq_in[7:0]};
   end else begin : g_narrow_only
      assign wr_shaped = wdata;
      assign rd_shaped = dq_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dq_out <= '0;
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         rvalid <= capture;
         if (start)   dq_out <= wr_shaped;
         if (capture) rdata  <= rd_shaped;
      end
   end

endmodule

// File: rtl/nand_cmd_port.sv
module nand_cmd_port
   import nand_port_pkg::*;
#(
   parameter int NUM_CS   = 4,
   parameter int CS_IDX_W = 3,
   parameter int DQ_W     = 16,
   parameter int CNT_W    = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 host_req,
   input  logic                 host_wr,
   input  logic [CS_IDX_W-1:0]  host_cs,
   input  logic [1:0]           host_win,
   input  logic [DQ_W-1:0]      host_wdata,
   output logic                 host_busy,
   output logic [DQ_W-1:0]      host_rdata,
   output logic                 host_rvalid,
   input  logic [1:0]           cfg_width,
   input  logic [CNT_W-1:0]     low_cnt,
   input  logic [CNT_W-1:0]     high_cnt,
   output logic [NUM_CS-1:0]    nand_ce_n,
   output logic                 nand_cle,
   output logic                 nand_ale,
   output logic                 nand_we_n,
   output logic                 nand_re_n,
   output logic                 nand_wp_n,
   output logic [DQ_W-1:0]      nand_dq_out,
   output logic                 nand_dq_oe,
   input  logic [DQ_W-1:0]      nand_dq_in
);

   if (NUM_CS < 1 || NUM_CS >= (1 << CS_IDX_W)) begin : g_bad_cs
      $error("NUM_CS must be at least 1 and below 2**CS_IDX_W");
   end
   if (DQ_W != 8 && DQ_W != 16) begin : g_bad_dq
      $error("DQ_W must be 8 or 16");
   end
   if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt
      $error("CNT_W must be 1 to 8");
   end

   logic              start;
   logic              wp_load;
   cyc_kind_t         kind_d;
   cyc_kind_t         kind_q;
   logic [NUM_CS-1:0] ce_sel_d;
   logic [NUM_CS-1:0] ce_sel_q;
   phase_e            phase;
   logic              busy;
   logic              rise;
   logic              wp_q;
   logic              wide_req;

   nand_req_decode #(
      .NUM_CS   (NUM_CS),
      .CS_IDX_W (CS_IDX_W)
   ) u_decode (
      .req     (host_req),
      .wr      (host_wr),
      .cs      (host_cs),
      .win     (host_win),
      .busy    (busy),
      .start   (start),
      .wp_load (wp_load),
      .kind    (kind_d),
      .ce_sel  (ce_sel_d)
   );

   nand_phase_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .low_cnt  (low_cnt),
      .high_cnt (high_cnt),
      .phase    (phase),
      .busy     (busy),
      .rise     (rise)
   );

   assign wide_req = (cfg_width == WIDE_CODE);

   nand_data_path #(
      .DQ_W (DQ_W)
   ) u_data (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .byte_only (kind_d.byte_only),
      .wide      (wide_req),
      .wdata     (host_wdata),
      .capture   (rise && kind_q.rd),
      .dq_in     (nand_dq_in),
      .dq_out    (nand_dq_out),
      .rdata     (host_rdata),
      .rvalid    (host_rvalid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q   <= '0;
         ce_sel_q <= '0;
         wp_q     <= 1'b0;
      end else begin
         if (start) begin
            kind_q   <= kind_d;
            ce_sel_q <= ce_sel_d;
         end
         if (wp_load) wp_q <= host_wdata[0];
      end
   end

   assign host_busy  = busy;
   assign nand_ce_n  = busy ? ~ce_sel_q : '1;
   assign nand_cle   = busy && kind_q.cle;
   assign nand_ale   = busy && kind_q.ale;
   assign nand_we_n  = !((phase == PH_LOW) && !kind_q.rd);
   assign nand_re_n  = !((phase == PH_LOW) && kind_q.rd);
   assign nand_dq_oe = busy && !kind_q.rd;
   assign nand_wp_n  = wp_q;

endmodule

// File: rtl/nand_port_chk.sv
module nand_port_chk #(
   parameter int NUM_CS   = 4,
   parameter int CS_IDX_W = 3,
   parameter int DQ_W     = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                host_req,
   input logic [CS_IDX_W-1:0] host_cs,
   input logic                host_busy,
   input logic                host_rvalid,
   input logic [NUM_CS-1:0]   nand_ce_n,
   input logic                nand_cle,
   input logic                nand_ale,
   input logic                nand_we_n,
   input logic                nand_re_n,
   input logic                nand_wp_n,
   input logic [DQ_W-1:0]     nand_dq_out,
   input logic                nand_dq_oe
);

   localparam logic [CS_IDX_W:0] CS_LIMIT = (CS_IDX_W+1)'(NUM_CS);

   p_cmd_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
      nand_cle |-> ((nand_dq_out >> 8) == '0));

   p_latch_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_cle && nand_ale));

   p_read_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_re_n |-> (!nand_dq_oe && !nand_cle && !nand_ale));

   p_rvalid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      host_rvalid |=> !host_rvalid);

   p_one_ce_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~nand_ce_n) <= 1);

   p_idle_ce_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !host_busy |-> (&nand_ce_n));

   p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nand_we_n && !nand_re_n));

   p_end_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(host_busy) |-> (nand_we_n && nand_re_n));

   p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && !host_busy && ({1'b0, host_cs} >= CS_LIMIT)) |=> !host_busy);

   p_wp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      host_busy |=> $stable(nand_wp_n));

endmodule

bind nand_cmd_port nand_port_chk #(
   .NUM_CS   (NUM_CS),
   .CS_IDX_W (CS_IDX_W),
   .DQ_W     (DQ_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .host_req    (host_req),
   .host_cs     (host_cs),
   .host_busy   (host_busy),
   .host_rvalid (host_rvalid),
   .nand_ce_n   (nand_ce_n),
   .nand_cle    (nand_cle),
   .nand_ale    (nand_ale),
   .nand_we_n   (nand_we_n),
   .nand_re_n   (nand_re_n),
   .nand_wp_n   (nand_wp_n),
   .nand_dq_out (nand_dq_out),
   .nand_dq_oe  (nand_dq_oe)
);

// File: tb/sim_nand_cmd_port.sv
module sim_nand_cmd_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 1'b0;
   logic        host_wr = 1'b0;
   logic [2:0]  host_cs = '0;
   logic [1:0]  host_win = '0;
   logic [15:0] host_wdata = '0;
   logic        host_busy;
   logic [15:0] host_rdata;
   logic        host_rvalid;
   logic [1:0]  cfg_width = 2'b00;
   logic [3:0]  low_cnt = 4'd1;
   logic [3:0]  high_cnt = 4'd1;
   logic [3:0]  nand_ce_n;
   logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_wp_n;
   logic [15:0] nand_dq_out;
   logic        nand_dq_oe;
   logic [15:0] nand_dq_in = '0;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   nand_cmd_port u0 (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
      .host_cs(host_cs), .host_win(host_win), .host_wdata(host_wdata),
      .host_busy(host_busy), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
      .cfg_width(cfg_width), .low_cnt(low_cnt), .high_cnt(high_cnt),
      .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
      .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_wp_n(nand_wp_n),
      .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // Full device cycle, sampled once per clock on the falling edge.
   task automatic do_op(input bit wr, input int cs, input logic [1:0] win,
                        input logic [15:0] wd, input logic [15:0] din,
                        input int l, input int h, input logic [1:0] cfg, input string tag);
      int le = (l == 0) ? 1 : l;
      int he = (h == 0) ? 1 : h;
      bit wide = (cfg == 2'b01);
      logic [15:0] exp_dq = (win == 2'b01 || !wide) ? {8'h00, wd[7:0]} : wd;
      logic [15:0] exp_rd = wide ? din : {8'h00, din[7:0]};
      logic exp_cle = wr && (win == 2'b01);
      logic exp_ale = wr && (win == 2'b10);
      logic [3:0] exp_ce = 4'b1111 ^ (4'b0001 << cs);
      @(negedge clk);
      host_req = 1'b1; host_wr = wr; host_cs = 3'(cs); host_win = win;
      host_wdata = wd; nand_dq_in = din; low_cnt = 4'(l); high_cnt = 4'(h); cfg_width = cfg;
      @(negedge clk);
      host_req = 1'b0;
      for (int i = 0; i < le; i++) begin
         chk({nand_we_n, nand_re_n, nand_cle, nand_ale, host_busy} ==
             {wr ? 1'b0 : 1'b1, wr ? 1'b1 : 1'b0, exp_cle, exp_ale, 1'b1},
             {tag, " R7 low phase strobes/latches"},
             {nand_we_n, nand_re_n, nand_cle, nand_ale, host_busy},
             {wr ? 1'b0 : 1'b1, wr ? 1'b1 : 1'b0, exp_cle, exp_ale, 1'b1});
         chk(nand_ce_n == exp_ce, {tag, " R6 ce low phase"}, nand_ce_n, exp_ce);
         if (wr) chk(nand_dq_oe && nand_dq_out == exp_dq, {tag, " R3 R5 dq_out"}, {nand_dq_oe, nand_dq_out}, {1'b1, exp_dq});
         else    chk(!nand_dq_oe, {tag, " R4 oe low on read"}, nand_dq_oe, 0);
         @(negedge clk);
      end
      for (int i = 0; i < he; i++) begin
         chk({nand_we_n, nand_re_n, host_busy, nand_ce_n} == {2'b11, 1'b1, exp_ce},
             {tag, " R7 high phase"}, {nand_we_n, nand_re_n, host_busy, nand_ce_n}, {2'b11, 1'b1, exp_ce});
         if (!wr && i == 0)
            chk(host_rvalid && host_rdata == exp_rd, {tag, " R4 R5 read data"}, {host_rvalid, host_rdata}, {1'b1, exp_rd});
         else
            chk(!host_rvalid, {tag, " R4 rvalid single pulse"}, host_rvalid, 0);
         @(negedge clk);
      end
      chk({host_busy, nand_ce_n, nand_cle, nand_ale, nand_dq_oe} == {1'b0, 4'b1111, 3'b000},
          {tag, " R6 R7 back to idle"}, {host_busy, nand_ce_n, nand_cle, nand_ale, nand_dq_oe}, {1'b0, 4'b1111, 3'b000});
   endtask

   task automatic t_reset();
      chk({nand_we_n, nand_re_n, nand_ce_n, nand_cle, nand_ale, nand_dq_oe, host_busy, host_rvalid} ==
          {2'b11, 4'b1111, 5'b00000}, "R11 reset outputs",
          {nand_we_n, nand_re_n, nand_ce_n, nand_cle, nand_ale, nand_dq_oe, host_busy, host_rvalid},
          {2'b11, 4'b1111, 5'b00000});
      chk(nand_wp_n == 1'b0, "R9 wp protected after reset", nand_wp_n, 0);
   endtask

   task automatic t_wp(input bit val);
      @(negedge clk);
      host_req = 1'b1; host_wr = 1'b1; host_win = 2'b11; host_cs = 3'd2; host_wdata = {15'h0, val};
      @(negedge clk);
      host_req = 1'b0;
      chk(nand_wp_n == val, "R9 wp follows control write", nand_wp_n, val);
      chk({host_busy, nand_we_n, nand_ce_n} == {1'b0, 1'b1, 4'b1111}, "R9 no device cycle on control write",
          {host_busy, nand_we_n, nand_ce_n}, {1'b0, 1'b1, 4'b1111});
   endtask

   task automatic t_reject(input int cs, input bit wr);
      @(negedge clk);
      host_req = 1'b1; host_wr = wr; host_win = 2'b00; host_cs = 3'(cs); host_wdata = 16'h5A5A;
      @(negedge clk);
      host_req = 1'b0;
      for (int i = 0; i < 2; i++) begin
         chk({host_busy, nand_we_n, nand_re_n, nand_ce_n} == {1'b0, 2'b11, 4'b1111},
             "R8 out-of-range select dropped", {host_busy, nand_we_n, nand_re_n, nand_ce_n}, {1'b0, 2'b11, 4'b1111});
         @(negedge clk);
      end
   endtask

   task automatic t_busy_ignore();
      @(negedge clk);
      host_req = 1'b1; host_wr = 1'b1; host_win = 2'b00; host_cs = 3'd0;
      host_wdata = 16'h0011; low_cnt = 4'd3; high_cnt = 4'd2; cfg_width = 2'b00;
      @(negedge clk);
      host_cs = 3'd3; host_win = 2'b01;
      chk({nand_ce_n, nand_cle} == {4'b1110, 1'b0}, "R10 ce kept on first select", {nand_ce_n, nand_cle}, {4'b1110, 1'b0});
      @(negedge clk);
      host_req = 1'b0;
      chk({nand_ce_n, nand_cle} == {4'b1110, 1'b0}, "R10 request while busy ignored", {nand_ce_n, nand_cle}, {4'b1110, 1'b0});
      repeat (4) @(negedge clk);
      chk({host_busy, nand_ce_n} == {1'b0, 4'b1111}, "R10 cycle ends after L+H", {host_busy, nand_ce_n}, {1'b0, 4'b1111});
      @(negedge clk);
      chk({host_busy, nand_we_n} == {1'b0, 1'b1}, "R10 no queued second cycle", {host_busy, nand_we_n}, {1'b0, 1'b1});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_wp(1'b1);
      do_op(1'b1, 1, 2'b01, 16'hABCD, 16'h0, 2, 3, 2'b01, "R1 cmd 16b");
      do_op(1'b1, 0, 2'b01, 16'h7790, 16'h0, 1, 1, 2'b00, "R1 cmd 8b");
      do_op(1'b1, 2, 2'b10, 16'h1234, 16'h0, 1, 1, 2'b00, "R2 addr 8b");
      do_op(1'b1, 3, 2'b10, 16'h4321, 16'h0, 3, 2, 2'b01, "R2 addr 16b");
      do_op(1'b1, 0, 2'b00, 16'hBEEF, 16'h0, 2, 2, 2'b01, "R3 data 16b");
      do_op(1'b1, 1, 2'b00, 16'hBEEF, 16'h0, 2, 2, 2'b11, "R5 cfg 11 is 8b");
      do_op(1'b0, 2, 2'b01, 16'h0, 16'hA55A, 2, 3, 2'b01, "R4 read cmd window 16b");
      do_op(1'b0, 3, 2'b10, 16'h0, 16'hA55A, 1, 1, 2'b10, "R4 read addr window 8b");
      do_op(1'b0, 0, 2'b11, 16'h0, 16'h3CC3, 1, 2, 2'b01, "R4 read ctrl window");
      do_op(1'b1, 1, 2'b00, 16'h0F0F, 16'h0, 0, 0, 2'b01, "R7 zero counts");
      do_op(1'b0, 2, 2'b00, 16'h0, 16'h9966, 15, 15, 2'b01, "R7 max counts");
      chk(nand_wp_n == 1'b1, "R9 wp held across cycles", nand_wp_n, 1);
      t_reject(4, 1'b1);
      t_reject(7, 1'b0);
      t_busy_ignore();
      t_wp(1'b0);
      done = 1'b1;
      summary();
   end

   initial begin
      for (int c = 0; c < 100000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

endmodule